// File: doc/BRIEF.md
# Single-Clock Dual-Port Memory with Per-Port Write Modes

This block is a synchronous memory with two independent access ports, A and B, on one clock. Each port has an enable, a write strobe, an address, write data and a registered read output. An enabled port either reads or writes its address on each rising edge. The result appears on that port's read output one clock later.

A per-port parameter picks what that port's own output shows in a cycle where the port writes. It can show the stored word as it was before the write, the word being written, or it can keep its last value. The setting has no effect on the other port.

Cross-port conflicts have fixed outcomes and are reported:
- When both ports write one address in the same cycle, port A's word is stored.
- When one port reads an address the other port is writing, the reader gets the old word.
- Each case raises its own flag, one clock later, aligned with the read data.

The block is meant for shared buffers whose two users run in the same clock domain.

Top module: `dpram_wm`

## Requirements
- R1: An enabled read (`x_en`=1, `x_we`=0) of an address that the other port is not writing puts the stored word on `x_rdata` after the next rising edge.
- R2: In mode `WM_READ_FIRST` (encoding 0), a port that writes shows, one clock later, the word its address held before that write.
- R3: In mode `WM_WRITE_FIRST` (encoding 1, the default for both ports), a port that writes shows its own write data one clock later.
- R4: In mode `WM_HOLD` (encoding 2), a port that writes leaves its read output unchanged.
- R5: If one port reads an address while the other port writes it in the same cycle, the reader returns the pre-write contents. The reader's write mode does not matter. `rd_clash` is 1 in the following cycle.
- R6: If both ports write the same address in the same cycle, port A's data is stored, and `wr_clash` is 1 in the following cycle.
- R7: A port with its enable low neither reads nor writes, even with `x_we` high, and its read output keeps its value.
- R8: While `rst_n` is low (asynchronous, active low), both read outputs and both flags are 0. The stored words survive reset.
- R9: When no collision of the kind in R5 or R6 occurs in a cycle, both flags are 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write strobe (1 = write) |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A registered read data |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write strobe (1 = write) |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B registered read data |
| wr_clash | output | 1 | Both ports wrote one address in the previous cycle |
| rd_clash | output | 1 | One port read an address the other wrote in the previous cycle |

## Verification
The bench runs three instances side by side, so each write mode is seen on each port. It drives collisions in both directions:
- If the reader saw forwarded data, it would return the new word instead of the old one.
- If the write priority were reversed, port B's word would show up on a later read.

The bench also applies a write strobe with the enable low. A design that ignored the enable would corrupt the word or move the output. Finally, a reset in the middle of the run must clear the outputs while a later read still finds the words written before it. A design that reset its storage, or did not clear its output registers, fails there.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  typedef enum logic [1:0] {
    WM_READ_FIRST  = 2'd0,
    WM_WRITE_FIRST = 2'd1,
    WM_HOLD        = 2'd2
  } wmode_e;
endpackage

// File: rtl/dpram_array.sv
// Storage array: combinational pre-write read per port, write priority to A.
module dpram_array #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              a_wr,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic              b_wr,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] a_old,
  output logic [DATA_W-1:0] b_old
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic              b_commit;

  assign a_old    = store[a_addr];
  assign b_old    = store[b_addr];
  // B yields when A writes the same word in the same cycle
  assign b_commit = b_wr && !(a_wr && (a_addr == b_addr));

  always_ff @(posedge clk) begin
    if (b_commit) store[b_addr] <= b_wdata;
    if (a_wr)     store[a_addr] <= a_wdata;
  end
endmodule

// File: rtl/dpram_port.sv
// One port's registered read output, with its write-mode selection.
module dpram_port
  import dpram_pkg::*;
#(
  parameter int     DATA_W = 16,
  parameter wmode_e MODE   = WM_WRITE_FIRST
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [DATA_W-1:0] old_data,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] rdata_d;
  logic              load;

  always_comb begin
    load    = 1'b0;
    rdata_d = rdata;
    if (en) begin
      if (!we) begin
        load    = 1'b1;
        rdata_d = old_data;
      end else if (MODE == WM_READ_FIRST) begin
        load    = 1'b1;
        rdata_d = old_data;
      end else if (MODE == WM_WRITE_FIRST) begin
        load    = 1'b1;
        rdata_d = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata <= '0;
    else if (load) rdata <= rdata_d;
  end
endmodule

// File: rtl/dpram_clash.sv
// Detects same-address conflicts between the ports; flags are registered.
module dpram_clash #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  output logic              wr_clash,
  output logic              rd_clash
);
  logic same, wr_d, rd_d;

  always_comb begin
    same = a_en && b_en && (a_addr == b_addr);
    wr_d = same && a_we && b_we;
    rd_d = same && (a_we != b_we);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_clash <= 1'b0;
      rd_clash <= 1'b0;
    end else begin
      wr_clash <= wr_d;
      rd_clash <= rd_d;
    end
  end
endmodule

// File: rtl/dpram_wm.sv
module dpram_wm
  import dpram_pkg::*;
#(
  parameter int     DATA_W = 16,
  parameter int     ADDR_W = 4,
  parameter wmode_e MODE_A = WM_WRITE_FIRST,
  parameter wmode_e MODE_B = WM_WRITE_FIRST
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              wr_clash,
  output logic              rd_clash
);
  logic              a_wr, b_wr;
  logic [DATA_W-1:0] a_old, b_old;

  assign a_wr = a_en && a_we;
  assign b_wr = b_en && b_we;

  dpram_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
    .clk(clk), .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata),
    .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata),
    .a_old(a_old), .b_old(b_old)
  );

  dpram_port #(.DATA_W(DATA_W), .MODE(MODE_A)) u_port_a (
    .clk(clk), .rst_n(rst_n), .en(a_en), .we(a_we),
    .old_data(a_old), .wdata(a_wdata), .rdata(a_rdata)
  );

  dpram_port #(.DATA_W(DATA_W), .MODE(MODE_B)) u_port_b (
    .clk(clk), .rst_n(rst_n), .en(b_en), .we(b_we),
    .old_data(b_old), .wdata(b_wdata), .rdata(b_rdata)
  );

  dpram_clash #(.ADDR_W(ADDR_W)) u_clash (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr),
    .wr_clash(wr_clash), .rd_clash(rd_clash)
  );
endmodule

// File: rtl/dpram_wm_chk.sv
module dpram_wm_chk
  import dpram_pkg::*;
#(
  parameter int     DATA_W = 16,
  parameter int     ADDR_W = 4,
  parameter wmode_e MODE_A = WM_WRITE_FIRST,
  parameter wmode_e MODE_B = WM_WRITE_FIRST
) (
  input logic              clk,
  input logic              rst_n,
  input logic              a_en,
  input logic              a_we,
  input logic [ADDR_W-1:0] a_addr,
  input logic [DATA_W-1:0] a_wdata,
  input logic [DATA_W-1:0] a_rdata,
  input logic              b_en,
  input logic              b_we,
  input logic [ADDR_W-1:0] b_addr,
  input logic [DATA_W-1:0] b_wdata,
  input logic [DATA_W-1:0] b_rdata,
  input logic              wr_clash,
  input logic              rd_clash
);
  logic same_addr;
  assign same_addr = a_en && b_en && (a_addr == b_addr);

  AST_IDLE_A_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !a_en |=> $stable(a_rdata)); // R7
  AST_IDLE_B_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !b_en |=> $stable(b_rdata)); // R7

  AST_WR_CLASH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (same_addr && a_we && b_we) |=> wr_clash); // R6
  AST_RD_CLASH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (same_addr && (a_we != b_we)) |=> rd_clash); // R5
  AST_NO_FALSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !same_addr |=> (!wr_clash && !rd_clash)); // R9

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (a_rdata == '0 && b_rdata == '0 && !wr_clash && !rd_clash); // R8
    end
  end

  if (MODE_A == WM_WRITE_FIRST) begin : g_wf_a
    AST_WF_ECHO_A: assert property (@(posedge clk) disable iff (!rst_n)
      (a_en && a_we) |=> (a_rdata == $past(a_wdata))); // R3
  end else if (MODE_A == WM_HOLD) begin : g_hold_a
    AST_HOLD_KEEP_A: assert property (@(posedge clk) disable iff (!rst_n)
      (a_en && a_we) |=> $stable(a_rdata)); // R4
  end

  if (MODE_B == WM_WRITE_FIRST) begin : g_wf_b
    AST_WF_ECHO_B: assert property (@(posedge clk) disable iff (!rst_n)
      (b_en && b_we) |=> (b_rdata == $past(b_wdata))); // R3
  end else if (MODE_B == WM_HOLD) begin : g_hold_b
    AST_HOLD_KEEP_B: assert property (@(posedge clk) disable iff (!rst_n)
      (b_en && b_we) |=> $stable(b_rdata)); // R4
  end
endmodule

bind dpram_wm dpram_wm_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MODE_A(MODE_A), .MODE_B(MODE_B)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
  .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
  .wr_clash(wr_clash), .rd_clash(rd_clash)
);

// File: tb/dpram_wm_tb.sv
module dpram_wm_tb;
  import dpram_pkg::*;

  localparam int DW = 16;
  localparam int AW = 4;
  localparam int NI = 3;
  localparam int NV = 12;

  // {a_en,a_we,a_addr,a_wd, b_en,b_we,b_addr,b_wd, exp_wr_clash, exp_rd_clash}
  localparam logic [45:0] VEC [NV] = '{
    {1'b1,1'b1,4'd1,16'h1111, 1'b1,1'b1,4'd2,16'h2222, 1'b0,1'b0},
    {1'b1,1'b0,4'd1,16'h0000, 1'b1,1'b0,4'd2,16'h0000, 1'b0,1'b0},
    {1'b1,1'b1,4'd1,16'hAAAA, 1'b1,1'b0,4'd1,16'h0000, 1'b0,1'b1},
    {1'b1,1'b0,4'd1,16'h0000, 1'b1,1'b1,4'd1,16'hBBBB, 1'b0,1'b1},
    {1'b1,1'b1,4'd3,16'h3333, 1'b1,1'b1,4'd3,16'h4444, 1'b1,1'b0},
    {1'b1,1'b0,4'd3,16'h0000, 1'b1,1'b0,4'd3,16'h0000, 1'b0,1'b0},
    {1'b0,1'b0,4'd0,16'h0000, 1'b1,1'b1,4'd5,16'h5555, 1'b0,1'b0},
    {1'b1,1'b1,4'd5,16'h6666, 1'b0,1'b0,4'd0,16'h0000, 1'b0,1'b0},
    {1'b0,1'b1,4'd5,16'hDEAD, 1'b0,1'b1,4'd5,16'hBEEF, 1'b0,1'b0},
    {1'b1,1'b0,4'd5,16'h0000, 1'b1,1'b0,4'd5,16'h0000, 1'b0,1'b0},
    {1'b1,1'b1,4'd7,16'h7777, 1'b1,1'b1,4'd8,16'h8888, 1'b0,1'b0},
    {1'b1,1'b0,4'd8,16'h0000, 1'b1,1'b0,4'd7,16'h0000, 1'b0,1'b0}
  };

  logic clk, rst_n;
  logic a_en, a_we, b_en, b_we;
  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_wdata, b_wdata;
  logic [DW-1:0] rd_a [NI];
  logic [DW-1:0] rd_b [NI];
  logic          wc [NI];
  logic          rc [NI];

  logic [DW-1:0] ref_mem [1<<AW];
  logic [DW-1:0] exp_a [NI];
  logic [DW-1:0] exp_b [NI];
  int checks, fails;
  bit done;

  function automatic wmode_e mode_of_a(int g);
    return (g == 0) ? WM_READ_FIRST : (g == 1) ? WM_WRITE_FIRST : WM_HOLD;
  endfunction
  function automatic wmode_e mode_of_b(int g);
    return (g == 0) ? WM_WRITE_FIRST : (g == 1) ? WM_HOLD : WM_READ_FIRST;
  endfunction

  for (genvar g = 0; g < NI; g++) begin : g_inst
    dpram_wm #(.DATA_W(DW), .ADDR_W(AW),
               .MODE_A(mode_of_a(g)), .MODE_B(mode_of_b(g))) u_dut (
      .clk(clk), .rst_n(rst_n),
      .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(rd_a[g]),
      .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(rd_b[g]),
      .wr_clash(wc[g]), .rd_clash(rc[g])
    );
  end

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string port_tag(logic en, logic we, logic oth_wr, logic same, wmode_e m);
    if (!en) return "R7";
    if (we) return (m == WM_READ_FIRST) ? "R2" : (m == WM_WRITE_FIRST) ? "R3" : "R4";
    if (oth_wr && same) return "R5";
    return "R1";
  endfunction

  function automatic logic [DW-1:0] next_out(logic en, logic we, wmode_e m,
      logic [DW-1:0] old, logic [DW-1:0] wd, logic [DW-1:0] cur);
    if (!en) return cur;
    if (!we) return old;
    if (m == WM_READ_FIRST) return old;
    if (m == WM_WRITE_FIRST) return wd;
    return cur;
  endfunction

  task automatic step(input logic ae, input logic awe, input logic [AW-1:0] aad,
                      input logic [DW-1:0] awd, input logic be, input logic bwe,
                      input logic [AW-1:0] bad, input logic [DW-1:0] bwd,
                      input logic ewc, input logic erc, input bit chk);
    logic [DW-1:0] old_a, old_b;
    logic same;
    @(negedge clk);
    a_en = ae; a_we = awe; a_addr = aad; a_wdata = awd;
    b_en = be; b_we = bwe; b_addr = bad; b_wdata = bwd;
    old_a = ref_mem[aad];
    old_b = ref_mem[bad];
    same  = (aad == bad);
    for (int g = 0; g < NI; g++) begin
      exp_a[g] = next_out(ae, awe, mode_of_a(g), old_a, awd, exp_a[g]);
      exp_b[g] = next_out(be, bwe, mode_of_b(g), old_b, bwd, exp_b[g]);
    end
    if (be && bwe) ref_mem[bad] = bwd;
    if (ae && awe) ref_mem[aad] = awd;   // A wins a same-address double write
    @(posedge clk);
    #1;
    if (chk) begin
      for (int g = 0; g < NI; g++) begin
        check(port_tag(ae, awe, be && bwe, same, mode_of_a(g)), $sformatf("inst%0d a_rdata", g),
              rd_a[g], exp_a[g]);
        check(port_tag(be, bwe, ae && awe, same, mode_of_b(g)), $sformatf("inst%0d b_rdata", g),
              rd_b[g], exp_b[g]);
        check(ewc ? "R6" : "R9", $sformatf("inst%0d wr_clash", g), {15'd0, wc[g]}, {15'd0, ewc});
        check(erc ? "R5" : "R9", $sformatf("inst%0d rd_clash", g), {15'd0, rc[g]}, {15'd0, erc});
      end
    end
  endtask

  task automatic check_reset_state(input string what);
    for (int g = 0; g < NI; g++) begin
      check("R8", {what, " a_rdata"}, rd_a[g], '0);
      check("R8", {what, " b_rdata"}, rd_b[g], '0);
      check("R8", {what, " flags"}, {14'd0, wc[g], rc[g]}, '0);
    end
  endtask

  initial begin
    checks = 0; fails = 0; done = 0;
    rst_n = 1'b0;
    a_en = 0; a_we = 0; a_addr = '0; a_wdata = '0;
    b_en = 0; b_we = 0; b_addr = '0; b_wdata = '0;
    for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;
    for (int g = 0; g < NI; g++) begin exp_a[g] = '0; exp_b[g] = '0; end
    repeat (2) @(posedge clk);
    #1;
    check_reset_state("power-up");
    @(negedge clk);
    rst_n = 1'b1;

    // Fill every word so later reads never see unwritten storage
    for (int k = 0; k < (1 << AW) / 2; k++)
      step(1'b1, 1'b1, AW'(2*k), 16'hC000 | DW'(2*k),
           1'b1, 1'b1, AW'(2*k+1), 16'hC000 | DW'(2*k+1), 1'b0, 1'b0, 1'b0);

    // Table walk: all three write modes on each port
    for (int v = 0; v < NV; v++)
      step(VEC[v][45], VEC[v][44], VEC[v][43:40], VEC[v][39:24],
           VEC[v][23], VEC[v][22], VEC[v][21:18], VEC[v][17:2],
           VEC[v][1], VEC[v][0], 1'b1);

    // R6: confirm A's word won the double write to address 3 (B=4444 discarded)
    step(1'b1, 1'b0, 4'd3, 16'h0, 1'b0, 1'b0, 4'd0, 16'h0, 1'b0, 1'b0, 1'b1);
    check("R6", "stored word after double write", ref_mem[3], 16'h3333);

    // R8: asynchronous reset mid-run clears outputs, keeps storage
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_reset_state("mid-run");
    for (int g = 0; g < NI; g++) begin exp_a[g] = '0; exp_b[g] = '0; end
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 1'b0, 4'd3, 16'h0, 1'b1, 1'b0, 4'd8, 16'h0, 1'b0, 1'b0, 1'b1);
    for (int g = 0; g < NI; g++) begin
      check("R8", "a_rdata after reset (storage kept)", rd_a[g], 16'h3333);
      check("R8", "b_rdata after reset (storage kept)", rd_b[g], 16'h8888);
    end

    // R7: both ports idle with write strobes high, then read back unchanged word
    step(1'b0, 1'b1, 4'd3, 16'hFFFF, 1'b0, 1'b1, 4'd3, 16'hEEEE, 1'b0, 1'b0, 1'b1);
    step(1'b1, 1'b0, 4'd3, 16'h0, 1'b1, 1'b0, 4'd3, 16'h0, 1'b0, 1'b0, 1'b1);
    check("R7", "word after idle strobes", rd_a[0], 16'h3333);

    $display("%0d/%0d checks passed", checks - fails, checks);
    done = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule